// File: doc/BRIEF.md
# Banked High-RAM Overlay Controller

This block sits on a byte-wide CPU bus and controls a 16 KB RAM that can replace the ROM in the address range $D000–$FFFF. The controller watches sixteen soft-switch addresses at $C080–$C08F. Each access to one of them changes three pieces of state. The first is which of two 4 KB banks appears at $D000–$DFFF. The second is whether reads in the high range come from the RAM or from the ROM. The third is a small counter that decides whether writes into the RAM are accepted.

For every bus access the block produces four outputs: a RAM read select, a RAM write enable, a ROM select and the 14-bit address presented to the RAM. The outputs are combinational from the current address, direction and strobe, and from the stored state. The stored state changes on the clock edge where a strobed soft-switch access is sampled. A switch access therefore governs the accesses that follow it, not itself.

Writing is armed only after two reads in a row of an odd-numbered switch, meaning a switch whose address bit 0 is 1. Any access to an even switch disarms it, and so does any write to an odd switch.

Top module: `lcbank_ctrl`

## Requirements
- R1: After a switch access with address bit 3 = 0, bank two is mapped. A $D000–$DFFF access then drives RAM address bit 12 to 1. After a switch access with bit 3 = 1, bank one is mapped and RAM address bit 12 is 0.
- R2: Address bit 2 of a switch access has no effect. $C084–$C087 behave exactly like $C080–$C083, and $C08C–$C08F behave exactly like $C088–$C08B.
- R3: Address bits [1:0] of a switch access set the read source. The values 00 and 11 select RAM reads. The values 01 and 10 select ROM reads.
- R4: A read or a write to a switch with address bit 0 = 0 clears the write counter. The RAM write enable then stays low for writes until the counter is rebuilt.
- R5: A read of a switch with address bit 0 = 1 increments the write counter, which saturates at 2. RAM writes are enabled only while the counter is 2, so one such read is not enough, two are, and any further reads keep writing enabled.
- R6: A write to a switch with address bit 0 = 1 clears the write counter. The same write still updates the read source (R3) and the bank (R1).
- R7: The RAM address for $E000–$FFFF is {1, A[12:0]} in every bank. The RAM address for $D000–$DFFF is {0, bank-two flag, A[11:0]}.
- R8: The ROM select and the RAM read select are driven only for strobed reads in $D000–$FFFF, and never both together. The RAM write enable is driven only for strobed writes in that range while writing is armed, whatever the read source. Outside the range all outputs, including the RAM address, are 0.
- R9: After reset, reads come from ROM, bank two is mapped and the write counter is 0.
- R10: Accesses outside $C080–$C08F, for example $C07F, $C090 or $C880, leave the bank, the read source and the write counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 16 | CPU address |
| busRdN | input | 1 | 1 = read, 0 = write |
| busStb | input | 1 | Valid access this cycle |
| ramRdSel | output | 1 | Read data from the overlay RAM |
| ramWrEn | output | 1 | Write the overlay RAM |
| romSel | output | 1 | Read data from the ROM |
| ramAddr | output | 14 | Address into the 16 KB RAM |

## Verification
Every one of the sixteen switches is tried as both a read and a write. Each is preceded by zero to three odd-switch reads, so it meets every counter value, including the saturated one. After each switch access, a probe read in the banked range and a probe write in the common range are checked against a model. The probe read separates the read-source rule from the bank rule. The probe write separates counter clearing from incrementing and saturation. Directed sequences cover four more cases: the reset state, addresses just outside the switch group, a RAM write while reads come from ROM, and the all-zero outputs outside the high range.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  typedef struct packed {
    logic load;
    logic cntClr;
    logic cntInc;
    logic rdEnNext;
    logic bankTwoNext;
  } lcbStrobe_t;
endpackage

// File: rtl/lcb_ctrl.sv
module lcb_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdN,
  input  logic              busStb,
  output lcb_pkg::lcbStrobe_t stb
);
  logic swHit;
  logic oddSw;

  assign swHit = busStb && (busAddr[ADDR_W-1:4] == SW_BASE[ADDR_W-1:4]);
  assign oddSw = busAddr[0];

  always_comb begin
    stb.load        = swHit;
    stb.cntClr      = swHit && (!oddSw || !busRdN);
    stb.cntInc      = swHit && oddSw && busRdN;
    stb.rdEnNext    = (busAddr[1] == busAddr[0]);
    stb.bankTwoNext = !busAddr[3];
  end

  // R4 R5: a switch access either clears or increments, never both
  a_r4_clr_inc_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.cntClr && stb.cntInc));

  // R10: no load strobe for an access outside the group
  a_r10_no_load_outside: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:4] != SW_BASE[ADDR_W-1:4]) |-> !stb.load);
endmodule

// File: rtl/lcb_datapath.sv
module lcb_datapath #(
  parameter int ADDR_W    = 16,
  parameter int WR_THRESH = 2,
  parameter int RAM_AW    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdN,
  input  logic              busStb,
  input  lcb_pkg::lcbStrobe_t stb,
  output logic              ramRdSel,
  output logic              ramWrEn,
  output logic              romSel,
  output logic [RAM_AW-1:0] ramAddr
);
  localparam int CNT_W = $clog2(WR_THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WR_THRESH);

  logic [CNT_W-1:0] wrCnt;
  logic rdEn;
  logic bankTwo;
  logic inHigh;
  logic inCommon;
  logic wrArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt   <= '0;
      rdEn    <= 1'b0;
      bankTwo <= 1'b1;
    end else if (stb.load) begin
      rdEn    <= stb.rdEnNext;
      bankTwo <= stb.bankTwoNext;
      if (stb.cntClr)
        wrCnt <= '0;
      else if (stb.cntInc && wrCnt != CNT_TOP)
        wrCnt <= wrCnt + 1'b1;
    end
  end

  assign wrArmed  = (wrCnt >= CNT_TOP);
  assign inHigh   = (busAddr[ADDR_W-1:ADDR_W-4] >= 4'hD);
  assign inCommon = (busAddr[ADDR_W-1:ADDR_W-3] == 3'b111);

  always_comb begin
    ramRdSel = busStb && busRdN && inHigh && rdEn;
    romSel   = busStb && busRdN && inHigh && !rdEn;
    ramWrEn  = busStb && !busRdN && inHigh && wrArmed;
    if (!inHigh)
      ramAddr = '0;
    else if (inCommon)
      ramAddr = {1'b1, busAddr[12:0]};
    else
      ramAddr = {1'b0, bankTwo, busAddr[11:0]};
  end

  // R5: counter never passes the threshold
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= CNT_TOP);

  // R4 R6: clearing strobe empties the counter
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.cntClr) |=> (wrCnt == '0));

  // R5: increment below saturation
  a_r5_inc: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.cntInc && wrCnt < CNT_TOP) |=> (wrCnt == $past(wrCnt) + 1'b1));

  // R8: the two read sources are never selected together
  a_r8_src_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRdSel && romSel));

  // R8: a write enable only during a strobed write
  a_r8_wr_dir: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (busStb && !busRdN));

  // R10: state holds without a load strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(wrCnt) && $stable(rdEn) && $stable(bankTwo)));
endmodule

// File: rtl/lcbank_ctrl.sv
module lcbank_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int WR_THRESH = 2,
  parameter int RAM_AW    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRdN,
  input  logic              busStb,
  output logic              ramRdSel,
  output logic              ramWrEn,
  output logic              romSel,
  output logic [RAM_AW-1:0] ramAddr
);
  lcb_pkg::lcbStrobe_t stb;

  lcb_ctrl #(.ADDR_W(ADDR_W), .SW_BASE(16'hC080)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdN(busRdN),
    .busStb(busStb), .stb(stb)
  );

  lcb_datapath #(.ADDR_W(ADDR_W), .WR_THRESH(WR_THRESH), .RAM_AW(RAM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdN(busRdN),
    .busStb(busStb), .stb(stb), .ramRdSel(ramRdSel), .ramWrEn(ramWrEn),
    .romSel(romSel), .ramAddr(ramAddr)
  );
endmodule

// File: tb/lcbank_ctrl_tb.sv
module lcbank_ctrl_tb;
  logic clk = 0;
  logic rstN = 0;
  logic [15:0] busAddr = 16'h0000;
  logic busRdN = 1;
  logic busStb = 0;
  logic ramRdSel, ramWrEn, romSel;
  logic [13:0] ramAddr;

  int nChecks = 0;
  int nFails  = 0;
  int mCnt;
  bit mRdEn;
  bit mBank2;
  logic sRd, sRom, sWr;
  logic [13:0] sAddr;

  always #5 clk = ~clk;

  lcbank_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdN(busRdN), .busStb(busStb),
    .ramRdSel(ramRdSel), .ramWrEn(ramWrEn), .romSel(romSel), .ramAddr(ramAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelApply(input logic [15:0] a, input bit rd);
    if (a[15:4] == 12'hC08) begin
      if (!a[0] || !rd) mCnt = 0;
      else if (mCnt < 2) mCnt++;
      mRdEn  = (a[1] == a[0]);
      mBank2 = !a[3];
    end
  endtask

  task automatic acc(input logic [15:0] a, input bit rd);
    @(negedge clk);
    busAddr = a; busRdN = rd; busStb = 1;
    #1;
    sRd = ramRdSel; sRom = romSel; sWr = ramWrEn; sAddr = ramAddr;
    @(posedge clk);
    #1 busStb = 0;
    modelApply(a, rd);
  endtask

  task automatic probe(input string rdTag, input string bkTag, input string wrTag);
    acc(16'hD5A3, 1);
    chk(rdTag, sRd, mRdEn);
    chk(rdTag, sRom, !mRdEn);
    chk(bkTag, sAddr, {1'b0, mBank2, 12'h5A3});
    acc(16'hF2C7, 0);
    chk(wrTag, sWr, (mCnt >= 2));
    chk("R7", sAddr, {1'b1, 13'h12C7});
  endtask

  initial begin
    #2000000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    mCnt = 0; mRdEn = 0; mBank2 = 1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R9 reset state
    probe("R9", "R9", "R9");

    // R1 R2 R3 R4 R5 R6 sweep over every switch and counter history
    for (int sw = 0; sw < 16; sw++)
      for (int rd = 0; rd < 2; rd++)
        for (int pre = 0; pre < 4; pre++) begin
          acc(16'hC080, 1);
          for (int k = 0; k < pre; k++) acc(16'hC08B, 1);
          acc(16'hC080 | 16'(sw), rd[0]);
          probe(sw[2] ? "R2" : "R3", sw[2] ? "R2" : "R1",
                sw[0] ? (rd[0] ? "R5" : "R6") : "R4");
        end

    // R5 one odd read is not enough, two are
    acc(16'hC080, 1); acc(16'hC083, 1);
    probe("R3", "R1", "R5");
    acc(16'hC083, 1);
    probe("R3", "R1", "R5");

    // R10 out-of-group addresses change nothing
    acc(16'hC08B, 1); acc(16'hC08B, 1);
    acc(16'hC07F, 1); acc(16'hC090, 0); acc(16'hC880, 1); acc(16'hC180, 0);
    probe("R10", "R10", "R10");
    chk("R10", mCnt, 2);

    // R8 write goes to RAM while reads come from ROM
    acc(16'hC089, 1); acc(16'hC089, 1);
    acc(16'hDABC, 0);
    chk("R8", sWr, 1);
    chk("R8", sRom, 0);
    chk("R7", sAddr, {2'b00, 12'hABC});
    acc(16'hEFFF, 1);
    chk("R8", sRom, 1);
    chk("R8", sRd, 0);
    chk("R7", sAddr, 14'h2FFF);

    // R8 outside the high range all outputs are zero
    acc(16'hC000, 1);
    chk("R8", {sRd, sRom, sWr, sAddr}, 17'h0);
    acc(16'hCFFF, 0);
    chk("R8", {sRd, sRom, sWr, sAddr}, 17'h0);
    acc(16'h0123, 0);
    chk("R8", {sRd, sRom, sWr, sAddr}, 17'h0);

    // R7 common region addresses across banks
    for (int b = 0; b < 2; b++) begin
      acc(b[0] ? 16'hC088 : 16'hC080, 1);
      for (int off = 0; off < 8192; off += 1021) begin
        acc(16'hE000 + 16'(off), 1);
        chk("R7", sAddr, {1'b1, 13'(off)});
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule